// File: doc/BRIEF.md
# Boundary Scan Test Access Port with Identification Word

This block is the test access port of a synchronous memory device. A sixteen-state controller is clocked by the test clock and steered by the mode-select line. It chooses between two paths: an instruction path and one of three data paths. The data paths are a one-bit bypass stage, a 32-bit identification word and a boundary chain. The boundary chain samples the device pins in parallel. It also holds placeholder cells that always read back as logic 1.

The chain is shifted serially toward the test data output. An update stage then transfers its pin cells to a latch. That latch can drive the device pins through a pin-drive test instruction. A sampling instruction with forced high impedance turns every output enable off while the pins are still observed. Under all other instructions, the functional output values and enables pass straight through to the pins.

Top module: `tap_scan_top`

## Requirements
- R1: An active-low asynchronous `trstN`, or five consecutive rising `tck` edges with `tms` high, put the controller in Test-Logic-Reset. Reaching Test-Logic-Reset loads the identification opcode 3'b001 as the current instruction. When the identification word is not built, it loads the bypass opcode 3'b111 instead.
- R2: In Capture-IR the 3-bit instruction shift stage loads 3'b001. Shift-IR moves the bits toward `tdo`, bit 0 first. The shifted value becomes the current instruction only in Update-IR.
- R3: Under opcode 3'b001, Capture-DR loads the 32-bit identification word. The fields from MSB down are: die revision in [31:28], zeros in [27:14], width code in [13:12] (x9=00, x18=01, x36=10, x72=11), an 11-bit vendor code in [11:1], and a 1 in bit 0. Bit 0 reaches `tdo` first.
- R4: Opcode 3'b111 selects the one-bit bypass stage, and so do the undefined opcodes 3'b100, 3'b101 and 3'b110. The bypass stage captures 0 and delays `tdi` by one shift.
- R5: Under sample/preload (3'b010), Capture-DR loads chain cell i with `pinLevel[i]` for i below NUM_PINS. The NUM_PAD placeholder cells above them load 1, whatever the pin levels are.
- R6: In Shift-DR the selected data register shifts one bit toward `tdo` on each rising edge, and `tdi` enters at its top cell. For the boundary chain, the bits shifted in reappear at `tdo` after NUM_PINS+NUM_PAD shifts.
- R7: `tdo` changes only on the falling edge of `tck`. `tdoOe` is high only for the falling-edge intervals that follow a rising edge leaving the controller in Shift-IR or Shift-DR.
- R8: Under pin drive (3'b000), `pinOe` is all ones and `pinOut` shows the pin-cell latch. Update-DR loads that latch from chain cells [NUM_PINS-1:0] under any boundary instruction, so a value preloaded under 3'b010 appears once 3'b000 is selected.
- R9: Under sampling with forced high impedance (3'b011), `pinOe` is all zeros and Capture-DR still samples `pinLevel` into the chain.
- R10: Under any instruction other than 3'b000, `pinOut` equals `funcOut`. Under any instruction other than 3'b000 and 3'b011, `pinOe` equals `funcOe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, updated on the falling edge |
| tdoOe | output | 1 | Output enable for tdo |
| pinLevel | input | NUM_PINS | Present levels of the device pins, sampled in Capture-DR |
| funcOut | input | NUM_PINS | Functional output values from the core |
| funcOe | input | NUM_PINS | Functional output enables from the core |
| pinOut | output | NUM_PINS | Value driven toward the pins |
| pinOe | output | NUM_PINS | Output enable toward the pins |

## Verification
The hardest case to reach from the ports is the preload path. A pattern has to be shifted into the boundary chain and latched in Update-DR under sample/preload. The chain must stay unchanged through an instruction scan. Only then, under pin drive, does the pattern appear on `pinOut`. The stimulus first runs a long boundary scan, twice the chain length, so that shifted-in bits return at `tdo` and the shift path is proven. It then preloads a known pattern, loads the pin-drive opcode and checks the pins before any further data scan. Every bit on `tdo` is also compared twice, once after the falling edge and once after the next rising edge, which shows that the output holds across the shift edge.

// File: rtl/tap_scan_pkg.sv
package tap_scan_pkg;

  localparam int IR_W = 3;

  localparam logic [IR_W-1:0] OP_PINDRIVE = 3'b000;
  localparam logic [IR_W-1:0] OP_IDENT    = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLE   = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLEZ  = 3'b011;
  localparam logic [IR_W-1:0] OP_BYPASS   = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE  = 3'b001;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tapState_e;

  typedef struct packed {
    logic inReset;
    logic capIr;
    logic shfIr;
    logic updIr;
    logic capDr;
    logic shfDr;
    logic updDr;
  } tapStrobe_t;

  function automatic logic [1:0] widthCode(input int dataWidth);
    case (dataWidth)
      9:       return 2'b00;
      18:      return 2'b01;
      36:      return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

endpackage

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import tap_scan_pkg::*;
(
  input  logic       tck,
  input  logic       trstN,
  input  logic       tms,
  output tapState_e  state,
  output tapStrobe_t strb
);

  tapState_e nextState;

  always_comb begin
    nextState = state;
    case (state)
      ST_RESET:  nextState = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nextState = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nextState = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nextState = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: nextState = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: nextState = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nextState = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nextState = tms ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: nextState = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nextState = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nextState = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: nextState = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: nextState = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nextState = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nextState = tms ? ST_UPD_IR : ST_SHF_IR;
      ST_UPD_IR: nextState = tms ? ST_SEL_DR : ST_IDLE;
      default:   nextState = ST_RESET;
    endcase
  end

  // R1: asynchronous reset and the all-ones path both land in ST_RESET
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) state <= ST_RESET;
    else        state <= nextState;
  end

  always_comb begin
    strb.inReset = (state == ST_RESET);
    strb.capIr   = (state == ST_CAP_IR);
    strb.shfIr   = (state == ST_SHF_IR);
    strb.updIr   = (state == ST_UPD_IR);
    strb.capDr   = (state == ST_CAP_DR);
    strb.shfDr   = (state == ST_SHF_DR);
    strb.updDr   = (state == ST_UPD_DR);
  end

endmodule

// File: rtl/tap_data.sv
module tap_data
  import tap_scan_pkg::*;
#(
  parameter int          NUM_PINS  = 8,
  parameter int          NUM_PAD   = 2,
  parameter bit          HAS_ID    = 1'b1,
  parameter logic [3:0]  DIE_REV   = 4'h2,
  parameter logic [10:0] VENDOR_ID = 11'h0A5,
  parameter int          IO_WIDTH  = 18
) (
  input  logic                tck,
  input  logic                trstN,
  input  logic                tdi,
  input  tapStrobe_t          strb,
  input  logic [NUM_PINS-1:0] pinLevel,
  input  logic [NUM_PINS-1:0] funcOut,
  input  logic [NUM_PINS-1:0] funcOe,
  output logic                tdo,
  output logic                tdoOe,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic [IR_W-1:0]     instr
);

  localparam int CHAIN = NUM_PINS + NUM_PAD;
  localparam logic [IR_W-1:0] RESET_OP = HAS_ID ? OP_IDENT : OP_BYPASS;
  localparam logic [31:0] ID_WORD = {DIE_REV, 14'd0, widthCode(IO_WIDTH), VENDOR_ID, 1'b1};

  logic [IR_W-1:0]     irShift;
  logic                bypassBit;
  logic [CHAIN-1:0]    bsr;
  logic [CHAIN-1:0]    capVec;
  logic [NUM_PINS-1:0] pinLatch;
  logic                idSer;
  logic                selBsr, selId, selByp;
  logic                serOut;

  // Instruction path (R1, R2)
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irShift <= '0;
      instr   <= RESET_OP;
    end else begin
      if (strb.capIr)      irShift <= IR_CAPTURE;
      else if (strb.shfIr) irShift <= {tdi, irShift[IR_W-1:1]};
      if (strb.inReset)    instr <= RESET_OP;
      else if (strb.updIr) instr <= irShift;
    end
  end

  // Decode; undefined codes fall through to bypass (R4)
  always_comb begin
    selBsr = (instr == OP_PINDRIVE) || (instr == OP_SAMPLE) || (instr == OP_SAMPLEZ);
    selId  = HAS_ID && (instr == OP_IDENT);
    selByp = !selBsr && !selId;
  end

  // Bypass stage
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                     bypassBit <= 1'b0;
    else if (strb.capDr && selByp)  bypassBit <= 1'b0;
    else if (strb.shfDr && selByp)  bypassBit <= tdi;
  end

  // Identification word (R3)
  generate
    if (HAS_ID) begin : g_id
      logic [31:0] idReg;
      always_ff @(posedge tck or negedge trstN) begin
        if (!trstN)                   idReg <= '0;
        else if (strb.capDr && selId) idReg <= ID_WORD;
        else if (strb.shfDr && selId) idReg <= {tdi, idReg[31:1]};
      end
      assign idSer = idReg[0];
    end else begin : g_noid
      assign idSer = 1'b0;
    end
  endgenerate

  // Boundary capture cells: pin cells then placeholder cells (R5)
  generate
    for (genvar i = 0; i < CHAIN; i++) begin : g_cell
      if (i < NUM_PINS) begin : g_pin
        assign capVec[i] = pinLevel[i];
      end else begin : g_pad
        assign capVec[i] = 1'b1;
      end
    end
  endgenerate

  // Boundary chain (R5, R6) and pin-cell update latch (R8)
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      bsr      <= '0;
      pinLatch <= '0;
    end else begin
      if (strb.capDr && selBsr)      bsr <= capVec;
      else if (strb.shfDr && selBsr) bsr <= {tdi, bsr[CHAIN-1:1]};
      if (strb.updDr && selBsr)      pinLatch <= bsr[NUM_PINS-1:0];
    end
  end

  always_comb begin
    if (strb.shfIr)  serOut = irShift[0];
    else if (selBsr) serOut = bsr[0];
    else if (selId)  serOut = idSer;
    else             serOut = bypassBit;
  end

  // Falling-edge output stage (R7)
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoOe <= 1'b0;
    end else begin
      tdo   <= serOut;
      tdoOe <= strb.shfIr || strb.shfDr;
    end
  end

  // Pin control (R8, R9, R10)
  always_comb begin
    pinOut = (instr == OP_PINDRIVE) ? pinLatch : funcOut;
    if (instr == OP_PINDRIVE)     pinOe = '1;
    else if (instr == OP_SAMPLEZ) pinOe = '0;
    else                          pinOe = funcOe;
  end

endmodule

// File: rtl/tap_scan_top.sv
module tap_scan_top
  import tap_scan_pkg::*;
#(
  parameter int          NUM_PINS  = 8,
  parameter int          NUM_PAD   = 2,
  parameter bit          HAS_ID    = 1'b1,
  parameter logic [3:0]  DIE_REV   = 4'h2,
  parameter logic [10:0] VENDOR_ID = 11'h0A5,
  parameter int          IO_WIDTH  = 18
) (
  input  logic                tck,
  input  logic                trstN,
  input  logic                tms,
  input  logic                tdi,
  output logic                tdo,
  output logic                tdoOe,
  input  logic [NUM_PINS-1:0] pinLevel,
  input  logic [NUM_PINS-1:0] funcOut,
  input  logic [NUM_PINS-1:0] funcOe,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe
);

  tapState_e       ctrlState;
  tapStrobe_t      strb;
  logic [IR_W-1:0] instr;

  tap_ctrl ctrl_i (
    .tck   (tck),
    .trstN (trstN),
    .tms   (tms),
    .state (ctrlState),
    .strb  (strb)
  );

  tap_data #(
    .NUM_PINS  (NUM_PINS),
    .NUM_PAD   (NUM_PAD),
    .HAS_ID    (HAS_ID),
    .DIE_REV   (DIE_REV),
    .VENDOR_ID (VENDOR_ID),
    .IO_WIDTH  (IO_WIDTH)
  ) data_i (
    .tck      (tck),
    .trstN    (trstN),
    .tdi      (tdi),
    .strb     (strb),
    .pinLevel (pinLevel),
    .funcOut  (funcOut),
    .funcOe   (funcOe),
    .tdo      (tdo),
    .tdoOe    (tdoOe),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .instr    (instr)
  );

endmodule

// File: rtl/tap_scan_chk.sv
module tap_scan_chk
  import tap_scan_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter bit HAS_ID   = 1'b1
) (
  input logic                tck,
  input logic                trstN,
  input logic                tms,
  input logic                tdoOe,
  input logic [NUM_PINS-1:0] funcOut,
  input logic [NUM_PINS-1:0] funcOe,
  input logic [NUM_PINS-1:0] pinOut,
  input logic [NUM_PINS-1:0] pinOe,
  input tapState_e           state,
  input logic [IR_W-1:0]     instr
);

  localparam logic [IR_W-1:0] RESET_OP = HAS_ID ? OP_IDENT : OP_BYPASS;

  logic [2:0] onesCnt;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                        onesCnt <= '0;
    else if (!tms)                     onesCnt <= '0;
    else if (onesCnt != 3'd5)          onesCnt <= onesCnt + 3'd1;
  end

  a_r1_five_ones_reset: assert property (@(posedge tck) disable iff (!trstN)
    (onesCnt == 3'd5) |-> (state == ST_RESET));

  a_r1_reset_loads_op: assert property (@(posedge tck) disable iff (!trstN)
    (state == ST_RESET) |=> (instr == RESET_OP));

  a_r7_tdo_oe_shift: assert property (@(posedge tck) disable iff (!trstN)
    tdoOe |-> ((state == ST_SHF_IR) || (state == ST_SHF_DR)));

  a_r8_drive_all_on: assert property (@(posedge tck) disable iff (!trstN)
    (instr == OP_PINDRIVE) |-> (pinOe == '1));

  a_r9_samplez_all_off: assert property (@(posedge tck) disable iff (!trstN)
    (instr == OP_SAMPLEZ) |-> (pinOe == '0));

  a_r10_func_pass: assert property (@(posedge tck) disable iff (!trstN)
    (instr != OP_PINDRIVE) |-> (pinOut == funcOut));

  a_r10_func_oe_pass: assert property (@(posedge tck) disable iff (!trstN)
    ((instr != OP_PINDRIVE) && (instr != OP_SAMPLEZ)) |-> (pinOe == funcOe));

endmodule

bind tap_scan_top tap_scan_chk #(.NUM_PINS(NUM_PINS), .HAS_ID(HAS_ID)) chk_i (
  .tck     (tck),
  .trstN   (trstN),
  .tms     (tms),
  .tdoOe   (tdoOe),
  .funcOut (funcOut),
  .funcOe  (funcOe),
  .pinOut  (pinOut),
  .pinOe   (pinOe),
  .state   (ctrlState),
  .instr   (instr)
);

// File: tb/tap_scan_top_tb_top.sv
`timescale 1ns/1ps
module tap_scan_top_tb_top;

  localparam int NP = 8;
  localparam logic [31:0] EXP_ID = {4'h2, 14'd0, 2'b01, 11'h0A5, 1'b1};

  logic          tck = 1'b0;
  logic          trstN, tms, tdi;
  logic          tdo, tdoOe;
  logic [NP-1:0] pinLevel, funcOut, funcOe, pinOut, pinOe;

  int checks = 0;
  int errors = 0;

  logic  expBits[$];
  string expTags[$];

  always #4 tck = ~tck;

  tap_scan_top dut_i (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .tdo(tdo), .tdoOe(tdoOe),
    .pinLevel(pinLevel), .funcOut(funcOut), .funcOe(funcOe),
    .pinOut(pinOut), .pinOe(pinOe)
  );

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic tmsV, input logic tdiV);
    @(negedge tck);
    #1;
    tms = tmsV;
    tdi = tdiV;
  endtask

  // Driver: pushes the expected tdo bits into the scoreboard, then drives the scan.
  task automatic irScan(input logic [2:0] op, input string tag);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 3; i++) begin
      expBits.push_back(IR_CAP_BIT(i));
      expTags.push_back(tag);
      tick(i == 2, op[i]);
    end
    tick(1, 0); tick(0, 0); tick(0, 0);
  endtask

  function automatic logic IR_CAP_BIT(input int i);
    logic [2:0] cap = 3'b001;
    return cap[i];
  endfunction

  task automatic drScan(input int n, input logic [63:0] din, input logic [63:0] exp, input string tag);
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) begin
      expBits.push_back(exp[i]);
      expTags.push_back(tag);
      tick(i == n - 1, din[i]);
    end
    tick(1, 0); tick(0, 0); tick(0, 0);
  endtask

  // Monitor: pops one expected bit per shift interval and compares it twice
  always @(negedge tck) begin
    #2;
    if (tdoOe) begin
      if (expBits.size() == 0) begin
        check(1'b0, "R7 unexpected tdo enable", 64'(tdo), 64'hx);
      end else begin
        logic  b;
        string t;
        b = expBits.pop_front();
        t = expTags.pop_front();
        check(tdo === b, t, 64'(tdo), 64'(b));
        @(posedge tck);
        #1;
        check(tdo === b, "R7 tdo held across rising edge", 64'(tdo), 64'(b));
      end
    end
  end

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    trstN = 0; tms = 1; tdi = 0;
    pinLevel = 8'hA6; funcOut = 8'h5A; funcOe = 8'hF0;
    repeat (3) @(negedge tck);
    #1 trstN = 1;
    tick(0, 0); tick(0, 0);

    // Reset state
    check(tdoOe == 1'b0, "R7 tdoOe low outside shift", 64'(tdoOe), 64'h0);
    check(pinOut == funcOut, "R10 reset pinOut pass", 64'(pinOut), 64'(funcOut));
    check(pinOe == funcOe, "R10 reset pinOe pass", 64'(pinOe), 64'(funcOe));

    // R1, R3: default instruction is the identification word
    drScan(32, 64'hDEAD_BEEF, 64'(EXP_ID), "R3 id word after reset R1");

    // R2, R4: bypass by the defined opcode
    irScan(3'b111, "R2 ir capture 001");
    drScan(5, 64'b10110, 64'b01100, "R4 bypass 111");
    check(pinOe == funcOe, "R10 bypass pinOe pass", 64'(pinOe), 64'(funcOe));

    // R4: undefined opcodes select bypass
    irScan(3'b101, "R2 ir capture 001");
    drScan(6, 64'b110011, 64'b100110, "R4 bypass undefined 101");
    irScan(3'b110, "R2 ir capture 001");
    drScan(4, 64'b0111, 64'b1110, "R4 bypass undefined 110");
    irScan(3'b100, "R2 ir capture 001");
    drScan(4, 64'b1001, 64'b0010, "R4 bypass undefined 100");

    // R1: five ones return to reset, identification selected again
    tick(1, 0); tick(1, 0); tick(1, 0); tick(1, 0); tick(1, 0);
    tick(0, 0); tick(0, 0);
    drScan(32, 64'h0, 64'(EXP_ID), "R1 five ones then id R3");

    // R5, R6: sample, long scan returns shifted-in bits
    irScan(3'b010, "R2 ir capture 001");
    pinLevel = 8'h3C;
    drScan(20, {44'd0, 10'h155, 10'h2D1}, {44'd0, 10'h2D1, 10'h33C}, "R6 chain shift length R5");
    check(pinOut == funcOut, "R10 sample pinOut pass", 64'(pinOut), 64'(funcOut));

    // R5: placeholder cells read 1, preload 0x69 into pin cells
    pinLevel = 8'hA6;
    drScan(10, 64'h169, 64'h3A6, "R5 capture pins and placeholders");
    pinLevel = 8'h00;
    drScan(10, 64'h100, 64'h300, "R5 placeholders one with pins low");

    // R8: preloaded value appears under pin drive
    irScan(3'b010, "R2 ir capture 001");
    drScan(10, 64'h169, 64'h300, "R5 capture before preload");
    irScan(3'b000, "R2 ir capture 001");
    check(pinOe == 8'hFF, "R8 pin drive enables", 64'(pinOe), 64'hFF);
    check(pinOut == 8'h69, "R8 preload driven", 64'(pinOut), 64'h69);
    pinLevel = 8'h0F;
    drScan(10, 64'h0C3, 64'h30F, "R8 capture under pin drive");
    check(pinOut == 8'hC3, "R8 updated drive value", 64'(pinOut), 64'hC3);

    // R9: forced high impedance while sampling
    irScan(3'b011, "R2 ir capture 001");
    check(pinOe == 8'h00, "R9 enables off", 64'(pinOe), 64'h0);
    check(pinOut == funcOut, "R10 samplez pinOut pass", 64'(pinOut), 64'(funcOut));
    pinLevel = 8'h81;
    drScan(10, 64'h0, 64'h381, "R9 sample under forced off");

    // R1: asynchronous reset restores identification
    irScan(3'b010, "R2 ir capture 001");
    @(negedge tck); #1 trstN = 0;
    @(negedge tck); #1 trstN = 1;
    check(pinOe == funcOe, "R1 trst pinOe back to functional", 64'(pinOe), 64'(funcOe));
    tick(0, 0);
    drScan(32, 64'h0, 64'(EXP_ID), "R1 trst then id word");

    repeat (4) @(negedge tck);
    check(expBits.size() == 0, "R6 all expected bits observed", 64'(expBits.size()), 64'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule